// File: doc/BRIEF.md
# Priority Switch Allocator with Crossbar

This block sits in a mesh router that has one extra link, the diagonal shortcut to the opposite corner of its quadrant. That link gives the router six ports: local, north, east, south, west and diagonal. Each input presents a word with a valid flag, a tail flag and the binary index of the output its route computation picked. The input raises the request only once that index is final. Every output has its own arbiter. In each cycle each arbiter picks at most one requester and returns a grant to it in the same cycle. The same grant matrix steers a crossbar, and the winning word leaves through the chosen output on the next clock edge.

Traffic that arrived over the diagonal link takes any free output ahead of the others. The five remaining inputs share each output in rotating order. A packet longer than one word keeps its output until its tail word has gone through, so the words of two packets are never mixed on one output. An input that is not granted keeps its word and request steady until the grant arrives.

Top module: `swa_switch`

## Requirements
- R1: While reset is asserted, and on its release, every `out_valid` bit is 0. No input is granted while no input is valid.
- R2: A word granted in cycle t appears in cycle t+1 on the output named by its `in_dest` code, with `out_valid` high and the same data and tail flag. Input indices and dest codes are 0 local, 1 north, 2 east, 3 south, 4 west, 5 diagonal.
- R3: When an output is not held by a packet, a request for it from input 5 (diagonal) is granted, whatever the other inputs request.
- R4: When input 5 does not request a free output, the output grants the first requester among inputs 0 to 4. The search starts one index past the last of these inputs that this output granted, wraps from 4 to 0, and starts at 0 after reset.
- R5: After an output grants a word whose tail flag is 0, it grants no other input, input 5 included, until that input's tail word is granted. In cycles where the holder presents no valid word for it, the output stays idle.
- R6: Each output arbitrates independently, so several outputs can grant different inputs in the same cycle.
- R7: `out_valid` of an output is 1 only in the cycle after exactly one input was granted on that output. A word that was not granted never reaches any output.
- R8: `in_grant` of an input is 1 only while that input's `in_valid` is 1, and it answers the single output that input requests.
- R9: An `in_dest` code of 6 or 7 requests no output. Such a word is never granted and produces no output word.
- R10: A word with its tail flag set on the first word is a one-word packet, and its output is free for any requester in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 6 | Per-input word valid, raised after route computation |
| in_dest | input | 18 | Per-input requested output index, 3 bits each, input i at [3i+2:3i] |
| in_tail | input | 6 | Per-input last-word-of-packet flag |
| in_data | input | 96 | Per-input data word, 16 bits each, input i at [16i+15:16i] |
| in_grant | output | 6 | Per-input grant, combinational in the request cycle |
| out_valid | output | 6 | Per-output word valid, registered |
| out_tail | output | 6 | Per-output last-word flag, registered |
| out_data | output | 96 | Per-output data word, 16 bits each, registered |

## Verification
The directed part of the test checks each arbitration rule on its own. Input 5 races a mesh input for one output, which shows the fixed priority. Three mesh inputs contend several times in a row, and the grant order shows whether the rotation starts past the last winner or is restarted from a fixed index. A multi-word packet with a bubble, while the diagonal input waits, shows that a held output refuses even its highest-priority input. A full permutation across all six outputs shows that the arbiters are independent, and invalid dest codes show that unknown requests are dropped. Constrained random traffic then mixes short and long packets, bubbles and heavy diagonal load, against a model written from the requirements. This catches grant, data-steering and hold errors that appear only when several rules interact.

// File: rtl/swa_pkg.sv
package swa_pkg;
  // input/output index assignment, shared by allocator, checker and bench
  localparam int unsigned PORT_LOCAL = 0;
  localparam int unsigned PORT_NORTH = 1;
  localparam int unsigned PORT_EAST  = 2;
  localparam int unsigned PORT_SOUTH = 3;
  localparam int unsigned PORT_WEST  = 4;
  localparam int unsigned PORT_DIAG  = 5;
  localparam int unsigned PORT_COUNT = 6;
endpackage

// File: rtl/swa_out_arb.sv
module swa_out_arb #(
  parameter int NP = 6,
  localparam int IW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic [NP-1:0] tail,
  output logic [NP-1:0] gnt
);
  // top index is the diagonal input; the rest share a rotating pointer
  localparam int NR = NP - 1;

  logic          held_q, held_d;
  logic [IW-1:0] own_q, own_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] win;
  logic          found;
  logic [IW:0]   cand;

  // grant selection
  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    cand  = '0;
    if (held_q) begin
      if (req[own_q]) begin
        gnt[own_q] = 1'b1;
        win        = own_q;
        found      = 1'b1;
      end
    end else if (req[NR]) begin
      gnt[NR] = 1'b1;
      win     = IW'(NR);
      found   = 1'b1;
    end else begin
      for (int k = 0; k < NR; k++) begin
        cand = {1'b0, ptr_q} + (IW+1)'(k);
        if (cand >= (IW+1)'(NR)) cand = cand - (IW+1)'(NR);
        if (!found && req[cand[IW-1:0]]) begin
          gnt[cand[IW-1:0]] = 1'b1;
          win               = cand[IW-1:0];
          found             = 1'b1;
        end
      end
    end
  end

  // next state: hold on a non-tail word, rotate pointer on a fresh mesh grant
  always_comb begin
    held_d = held_q;
    own_d  = own_q;
    ptr_d  = ptr_q;
    if (found) begin
      held_d = !tail[win];
      own_d  = win;
      if (!held_q && (win != IW'(NR))) begin
        ptr_d = (win == IW'(NR - 1)) ? '0 : win + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      own_q  <= '0;
      ptr_q  <= '0;
    end else if (found) begin
      held_q <= held_d;
      own_q  <= own_d;
      ptr_q  <= ptr_d;
    end
  end
endmodule

// File: rtl/swa_xbar.sv
module swa_xbar #(
  parameter int NP = 6,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP*NP-1:0] gnt_flat,
  input  logic [NP-1:0]    in_tail,
  input  logic [NP*DW-1:0] in_data,
  output logic [NP-1:0]    out_valid,
  output logic [NP-1:0]    out_tail,
  output logic [NP*DW-1:0] out_data
);
  logic [NP-1:0]    any_d;
  logic [NP-1:0]    tail_d;
  logic [NP*DW-1:0] data_d;

  // AND-OR select per output, driven by that output's grant column
  always_comb begin
    any_d  = '0;
    tail_d = '0;
    data_d = '0;
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        if (gnt_flat[o*NP+i]) begin
          any_d[o]            = 1'b1;
          tail_d[o]           = tail_d[o] | in_tail[i];
          data_d[o*DW +: DW]  = data_d[o*DW +: DW] | in_data[i*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
    end else begin
      out_valid <= any_d;
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_tail[o]           <= 1'b0;
        out_data[o*DW +: DW]  <= '0;
      end else if (any_d[o]) begin
        out_tail[o]           <= tail_d[o];
        out_data[o*DW +: DW]  <= data_d[o*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/swa_switch.sv
module swa_switch #(
  parameter int NP = swa_pkg::PORT_COUNT,
  parameter int DW = 16,
  localparam int PW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*PW-1:0] in_dest,
  input  logic [NP-1:0]    in_tail,
  input  logic [NP*DW-1:0] in_data,
  output logic [NP-1:0]    in_grant,
  output logic [NP-1:0]    out_valid,
  output logic [NP-1:0]    out_tail,
  output logic [NP*DW-1:0] out_data
);
  logic [NP*NP-1:0] req_flat;
  logic [NP*NP-1:0] gnt_flat;

  // request decode: input i asks output o when its dest code equals o
  for (genvar o = 0; o < NP; o++) begin : g_req_o
    for (genvar i = 0; i < NP; i++) begin : g_req_i
      assign req_flat[o*NP+i] = in_valid[i] && (in_dest[i*PW +: PW] == PW'(o));
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_arb
    swa_out_arb #(.NP(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_flat[o*NP +: NP]),
      .tail  (in_tail),
      .gnt   (gnt_flat[o*NP +: NP])
    );
  end

  // each input requests one output, so OR over outputs is its grant
  always_comb begin
    in_grant = '0;
    for (int o = 0; o < NP; o++) begin
      in_grant = in_grant | gnt_flat[o*NP +: NP];
    end
  end

  swa_xbar #(.NP(NP), .DW(DW)) u_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_flat  (gnt_flat),
    .in_tail   (in_tail),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_tail  (out_tail),
    .out_data  (out_data)
  );
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
  parameter int NP = 6,
  parameter int DW = 16,
  localparam int PW = $clog2(NP)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP-1:0]    in_valid,
  input logic [NP*PW-1:0] in_dest,
  input logic [NP-1:0]    in_tail,
  input logic [NP*DW-1:0] in_data,
  input logic [NP-1:0]    in_grant,
  input logic [NP-1:0]    out_valid,
  input logic [NP*DW-1:0] out_data,
  input logic [NP*NP-1:0] gnt_flat
);
  // output ownership rebuilt from port traffic only
  logic [NP-1:0] busy_q;
  logic [PW-1:0] own_q [NP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int o = 0; o < NP; o++) own_q[o] <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        for (int i = 0; i < NP; i++) begin
          if (in_grant[i] && (in_dest[i*PW +: PW] == PW'(o))) begin
            busy_q[o] <= !in_tail[i];
            own_q[o]  <= PW'(i);
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_in
    p_grant_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_grant[i] |-> in_valid[i]);
  end

  for (genvar o = 0; o < NP; o++) begin : g_o
    p_diag_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q[o] && in_valid[NP-1] && (in_dest[(NP-1)*PW +: PW] == PW'(o)))
      |-> in_grant[NP-1]);

    p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> $past($countones(gnt_flat[o*NP +: NP]) == 1));

    for (genvar i = 0; i < NP; i++) begin : g_i
      p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_grant[i] && (in_dest[i*PW +: PW] == PW'(o)))
        |=> (out_valid[o] && (out_data[o*DW +: DW] == $past(in_data[i*DW +: DW]))));

      p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q[o] && in_grant[i] && (in_dest[i*PW +: PW] == PW'(o)))
        |-> (own_q[o] == PW'(i)));
    end
  end
endmodule

bind swa_switch swa_checker #(.NP(NP), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_dest  (in_dest),
  .in_tail  (in_tail),
  .in_data  (in_data),
  .in_grant (in_grant),
  .out_valid(out_valid),
  .out_data (out_data),
  .gnt_flat (gnt_flat)
);

// File: tb/swa_switch_test.sv
module swa_switch_test;
  localparam int NP = 6;
  localparam int DW = 16;
  localparam int PW = 3;
  localparam int DG = NP - 1;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [NP-1:0]    in_valid, in_tail, in_grant, out_valid, out_tail;
  logic [NP*PW-1:0] in_dest;
  logic [NP*DW-1:0] in_data, out_data;

  logic          vv [NP];
  logic          tt [NP];
  logic [PW-1:0] ds [NP];
  logic [DW-1:0] dd [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_valid[i]          = vv[i];
      in_tail[i]           = tt[i];
      in_dest[i*PW +: PW]  = ds[i];
      in_data[i*DW +: DW]  = dd[i];
    end
  end

  swa_switch #(.NP(NP), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_dest(in_dest), .in_tail(in_tail), .in_data(in_data),
    .in_grant(in_grant), .out_valid(out_valid), .out_tail(out_tail), .out_data(out_data)
  );

  // reference state written from the requirements
  logic          m_held [NP];
  int            m_own  [NP];
  int            m_ptr  [NP];
  int            m_win  [NP];
  logic [NP-1:0] g_exp;
  logic [NP-1:0] e_valid, e_tail;
  logic [DW-1:0] e_data [NP];
  logic          in_pkt [NP];
  logic [PW-1:0] pk_dst [NP];

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_eval();
    g_exp = '0;
    for (int o = 0; o < NP; o++) begin
      m_win[o] = -1;
      if (m_held[o]) begin
        if (vv[m_own[o]] && (int'(ds[m_own[o]]) == o)) m_win[o] = m_own[o];
      end else if (vv[DG] && (int'(ds[DG]) == o)) begin
        m_win[o] = DG;
      end else begin
        for (int k = 0; k < NP - 1; k++) begin
          int c;
          c = (m_ptr[o] + k) % (NP - 1);
          if (m_win[o] < 0 && vv[c] && (int'(ds[c]) == o)) m_win[o] = c;
        end
      end
      if (m_win[o] >= 0) g_exp[m_win[o]] = 1'b1;
    end
  endtask

  task automatic step();
    #1;
    model_eval();
    chk("R2 R3 R4 R5 R6 R8 grant", 64'(in_grant), 64'(g_exp));
    for (int o = 0; o < NP; o++) begin
      e_valid[o] = (m_win[o] >= 0);
      e_tail[o]  = 1'b0;
      e_data[o]  = '0;
      if (m_win[o] >= 0) begin
        e_tail[o] = tt[m_win[o]];
        e_data[o] = dd[m_win[o]];
        if (!m_held[o] && m_win[o] != DG) m_ptr[o] = (m_win[o] + 1) % (NP - 1);
        m_held[o] = !tt[m_win[o]];
        m_own[o]  = m_win[o];
      end
    end
    @(posedge clk);
    #1;
    chk("R2 R7 out_valid", 64'(out_valid), 64'(e_valid));
    for (int o = 0; o < NP; o++) begin
      if (e_valid[o]) chk("R2 out word", {out_tail[o], out_data[o*DW +: DW]}, {e_tail[o], e_data[o]});
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NP; i++) begin
      vv[i] = 1'b0; tt[i] = 1'b0; ds[i] = '0; dd[i] = '0;
    end
  endtask

  task automatic expg(input string tag, input logic [NP-1:0] g);
    #1;
    chk(tag, 64'(in_grant), 64'(g));
  endtask

  task automatic put(input int i, input int d, input logic t, input logic [DW-1:0] w);
    vv[i] = 1'b1; ds[i] = PW'(d); tt[i] = t; dd[i] = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clr();
    for (int o = 0; o < NP; o++) begin
      m_held[o] = 1'b0; m_own[o] = 0; m_ptr[o] = 0;
    end
    for (int i = 0; i < NP; i++) begin
      in_pkt[i] = 1'b0; pk_dst[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R1 grant idle", 64'(in_grant), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 out_valid after release", 64'(out_valid), 64'd0);

    // R3 then R10: diagonal beats north; one-word packet frees output 2
    put(1, 2, 1'b1, 16'h0101); put(5, 2, 1'b1, 16'h0505);
    expg("R3 diagonal wins", 6'b100000); step();
    vv[5] = 1'b0;
    expg("R10 released after one word", 6'b000010); step();
    clr();

    // R4: rotation on output 2, pointer now past input 1
    put(0, 2, 1'b1, 16'h1000); put(1, 2, 1'b1, 16'h1001); put(3, 2, 1'b1, 16'h1003);
    expg("R4 start past last winner", 6'b001000); step();
    vv[3] = 1'b0;
    expg("R4 wrap to input 0", 6'b000001); step();
    vv[0] = 1'b0;
    expg("R4 then input 1", 6'b000010); step();
    clr();

    // R5: held output 3 ignores diagonal during owner bubble
    put(0, 3, 1'b0, 16'h2000);
    expg("R5 head granted", 6'b000001); step();
    vv[0] = 1'b0; put(4, 3, 1'b1, 16'h2004); put(5, 3, 1'b1, 16'h2005);
    expg("R5 held output idle", 6'b000000); step();
    put(0, 3, 1'b1, 16'h2001);
    expg("R5 owner tail", 6'b000001); step();
    vv[0] = 1'b0;
    expg("R3 after release", 6'b100000); step();
    vv[5] = 1'b0;
    expg("R4 west after diagonal", 6'b010000); step();
    clr();

    // R6: full permutation, all outputs at once
    for (int i = 0; i < NP; i++) put(i, (i + 1) % NP, 1'b1, DW'(16'h3000 + i));
    expg("R6 all granted", 6'b111111); step();
    clr();

    // R9: unknown dest codes
    put(0, 6, 1'b1, 16'h4000); put(2, 7, 1'b1, 16'h4002);
    expg("R9 no grant", 6'b000000); step();
    chk("R9 outputs idle", 64'(out_valid), 64'd0);
    clr(); step();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NP; i++) begin
        if (g_exp[i]) begin
          in_pkt[i] = !tt[i];
          pk_dst[i] = ds[i];
        end
        if (vv[i] && !g_exp[i]) begin
          // stalled word stays as it was
        end else if (in_pkt[i]) begin
          vv[i] = ($urandom % 4) != 0;
          ds[i] = pk_dst[i];
          tt[i] = ($urandom % 3) == 0;
          dd[i] = DW'($urandom);
        end else begin
          vv[i] = ($urandom % 5) < 3;
          ds[i] = PW'($urandom % NP);
          tt[i] = ($urandom % 2) == 0;
          dd[i] = DW'($urandom);
        end
      end
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule